// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block is a test data register that sits behind a boundary-scan TAP controller and gives an external debugger read and write access to a small on-chip register space. The TAP controller supplies the current instruction and one-cycle capture, shift and update strobes. The block turns each completed scan into one request on a simple downstream register bus.

Each access scan moves a 40-bit frame, least significant bit first. The frame carries a 32-bit data word, a 7-bit register address and a direction bit. Reads are pipelined across scans. The data that shifts out during a scan is the result of the read requested by the previous read scan. A debugger that reads a burst therefore ends it with one more read of register 0, the identification register, to collect the last result without using up another data word.

A second, 5-bit data register holds the scan-chain number. It is reached through its own instruction. Register access works only while chain 0 is selected.

Top module: `dbg_acc_chain`

## Requirements
- R1: An access frame is 40 bits, shifted in on `tdi` and out on `tdo` least significant bit first. Bits 31:0 carry data, bits 38:32 carry the register address and bit 39 carries the direction.
- R2: A direction bit of 0 requests a read and 1 requests a write. A write request presents the shifted data bits 31:0 on `bus_wdata`. Every request presents the shifted address on `bus_addr` and the direction on `bus_write`.
- R3: `bus_req` is high for exactly one cycle: the cycle after the clock edge that samples `dr_update`, when access is enabled.
- R4: At capture the frame is loaded with the most recent read result in bits 31:0 and with zeros in bits 39:32. After reset the held read result is 0.
- R5: The data shifted out during an access scan is the value `bus_rdata` returned by the most recent earlier read request. Write requests leave that held value unchanged.
- R6: Access is enabled only while the instruction is 0xC and the selected chain is 0. At any other time access strobes issue no request, and `tdo` is 0 unless the chain-select register is selected.
- R7: Instruction 0x2 selects the 5-bit chain-select register, which is shifted least significant bit first. Its capture loads the current chain number, and the new number takes effect at update.
- R8: While `rst_n` is low, the selected chain is 0 and `bus_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low TAP reset, asynchronous |
| ir | input | 4 | Instruction currently held by the TAP |
| dr_capture | input | 1 | Capture-DR strobe |
| dr_shift | input | 1 | Shift-DR strobe, one bit per cycle |
| dr_update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| active_chain | output | 5 | Currently selected scan chain |
| bus_req | output | 1 | One-cycle register-bus request |
| bus_write | output | 1 | Request direction, 1 = write |
| bus_addr | output | 7 | Request register address |
| bus_wdata | output | 32 | Request write data |
| bus_rdata | input | 32 | Read data, valid in the request cycle |

## Verification
There are three pieces of internal state whose corruption reaches the ports.

- **Held read result.** A wrong value appears on `tdo` in bits 0 to 31 of the very next access scan. Comparing each frame against the bench's own record of the last read address exposes a lost or doubled pipeline stage within one scan.
- **Chain number.** A wrong chain number shows on `active_chain` one cycle after update. It also shows as a missing or spurious `bus_req` on the next access scan.
- **Request register.** A bad request register shows in the cycle right after update, as wrong `bus_addr`, `bus_write` or `bus_wdata`, or as a request that lasts longer than one cycle.

// File: rtl/dbg_acc_pkg.sv
package dbg_acc_pkg;

   // which serial register drives tdo
   typedef enum logic [1:0] {
      TDO_NONE = 2'd0,
      TDO_SEL  = 2'd1,
      TDO_ACC  = 2'd2
   } tdo_src_e;

   // which value the chain-select register captures
   typedef enum logic {
      CAP_ZERO     = 1'b0,
      CAP_READBACK = 1'b1
   } sel_cap_e;

endpackage

// File: rtl/dbg_chain_sel.sv
module dbg_chain_sel
   import dbg_acc_pkg::*;
#(
   parameter int       SEL_W   = 5,
   parameter sel_cap_e CAP_SRC = CAP_READBACK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             capture,
   input  logic             shift,
   input  logic             update,
   input  logic             tdi,
   output logic             tdo,
   output logic [SEL_W-1:0] chain
);

   logic [SEL_W-1:0] sr;
   logic [SEL_W-1:0] cap_val;

   generate
      if (CAP_SRC == CAP_READBACK) begin : g_readback
         assign cap_val = chain;
      end else begin : g_zero
         assign cap_val = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         chain <= '0;
      end else if (en) begin
         if (capture)
            sr <= cap_val;
         else if (shift)
            sr <= {tdi, sr[SEL_W-1:1]};
         if (update)
            chain <= sr;
      end
   end

   assign tdo = sr[0];

endmodule

// File: rtl/dbg_acc_shifter.sv
module dbg_acc_shifter #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 7,
   localparam int FR_W  = DATA_W + ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              capture,
   input  logic              shift,
   input  logic              tdi,
   input  logic [DATA_W-1:0] cap_data,
   output logic              tdo,
   output logic [FR_W-1:0]   frame
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame <= '0;
      else if (en) begin
         if (capture)
            frame <= {{(ADDR_W + 1){1'b0}}, cap_data};
         else if (shift)
            frame <= {tdi, frame[FR_W-1:1]};
      end
   end

   assign tdo = frame[0];

endmodule

// File: rtl/dbg_bus_issue.sv
module dbg_bus_issue #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 7,
   localparam int FR_W  = DATA_W + ADDR_W + 1,
   localparam int DIR_B = FR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [FR_W-1:0]   frame,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rd_hold
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_write <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
      end else begin
         bus_req <= fire;
         if (fire) begin
            bus_write <= frame[DIR_B];
            bus_addr  <= frame[DATA_W +: ADDR_W];
            bus_wdata <= frame[DATA_W-1:0];
         end
      end
   end

   // read result is held until the next read request completes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_hold <= '0;
      else if (bus_req && !bus_write)
         rd_hold <= bus_rdata;
   end

endmodule

// File: rtl/dbg_acc_chain.sv
module dbg_acc_chain
   import dbg_acc_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 7,
   parameter int          SEL_W      = 5,
   parameter int          IR_W       = 4,
   parameter logic [3:0]  IR_ACCESS  = 4'hC,
   parameter logic [3:0]  IR_SCANSEL = 4'h2,
   parameter int          ACC_CHAIN  = 0,
   parameter sel_cap_e    SEL_CAP    = CAP_READBACK,
   localparam int         FR_W       = DATA_W + ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IR_W-1:0]   ir,
   input  logic              dr_capture,
   input  logic              dr_shift,
   input  logic              dr_update,
   input  logic              tdi,
   output logic              tdo,
   output logic [SEL_W-1:0]  active_chain,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);

   generate
      if (DATA_W < 1)       begin : g_bad_data  $error("DATA_W must be at least 1");  end
      if (ADDR_W < 1)       begin : g_bad_addr  $error("ADDR_W must be at least 1");  end
      if (SEL_W < 2)        begin : g_bad_sel   $error("SEL_W must be at least 2");   end
      if (IR_W < 1 || IR_W > 4) begin : g_bad_ir $error("IR_W must be 1 to 4");      end
      if (IR_ACCESS == IR_SCANSEL) begin : g_bad_codes $error("instruction codes must differ"); end
      if (ACC_CHAIN < 0 || ACC_CHAIN >= (1 << SEL_W)) begin : g_bad_chain $error("ACC_CHAIN out of range"); end
   endgenerate

   logic              sel_en;
   logic              acc_en;
   logic              sel_tdo;
   logic              acc_tdo;
   logic [FR_W-1:0]   frame;
   logic [DATA_W-1:0] rd_hold;
   tdo_src_e          tdo_src;

   assign sel_en = (ir == IR_SCANSEL[IR_W-1:0]);
   assign acc_en = (ir == IR_ACCESS[IR_W-1:0]) && (active_chain == SEL_W'(ACC_CHAIN));

   dbg_chain_sel #(
      .SEL_W   (SEL_W),
      .CAP_SRC (SEL_CAP)
   ) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (sel_en),
      .capture (dr_capture),
      .shift   (dr_shift),
      .update  (dr_update),
      .tdi     (tdi),
      .tdo     (sel_tdo),
      .chain   (active_chain)
   );

   dbg_acc_shifter #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (acc_en),
      .capture  (dr_capture),
      .shift    (dr_shift),
      .tdi      (tdi),
      .cap_data (rd_hold),
      .tdo      (acc_tdo),
      .frame    (frame)
   );

   dbg_bus_issue #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (dr_update && acc_en),
      .frame     (frame),
      .bus_rdata (bus_rdata),
      .bus_req   (bus_req),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .rd_hold   (rd_hold)
   );

   always_comb begin
      if (sel_en)      tdo_src = TDO_SEL;
      else if (acc_en) tdo_src = TDO_ACC;
      else             tdo_src = TDO_NONE;
   end

   always_comb begin
      unique case (tdo_src)
         TDO_SEL: tdo = sel_tdo;
         TDO_ACC: tdo = acc_tdo;
         default: tdo = 1'b0;
      endcase
   end

endmodule

// File: rtl/dbg_acc_chain_chk.sv
module dbg_acc_chain_chk #(
   parameter int         ADDR_W     = 7,
   parameter int         SEL_W      = 5,
   parameter int         IR_W       = 4,
   parameter logic [3:0] IR_ACCESS  = 4'hC,
   parameter logic [3:0] IR_SCANSEL = 4'h2,
   parameter int         ACC_CHAIN  = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IR_W-1:0]  ir,
   input logic             dr_update,
   input logic [SEL_W-1:0] active_chain,
   input logic             bus_req
);

   logic acc_ok;
   assign acc_ok = (ir == IR_ACCESS[IR_W-1:0]) && (active_chain == SEL_W'(ACC_CHAIN));

   // R3: a request only ever follows an update strobe
   p_req_after_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> $past(dr_update));

   // R3: an enabled update always yields a request next cycle
   p_update_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_update && acc_ok) |=> bus_req);

   // R6: an update without access enabled yields no request
   p_gated_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_update && !acc_ok) |=> !bus_req);

   // R7: the chain number changes only through an update of the select register
   p_chain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(dr_update && ir == IR_SCANSEL[IR_W-1:0]) |=> $stable(active_chain));

endmodule

bind dbg_acc_chain dbg_acc_chain_chk #(
   .ADDR_W     (ADDR_W),
   .SEL_W      (SEL_W),
   .IR_W       (IR_W),
   .IR_ACCESS  (IR_ACCESS),
   .IR_SCANSEL (IR_SCANSEL),
   .ACC_CHAIN  (ACC_CHAIN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ir           (ir),
   .dr_update    (dr_update),
   .active_chain (active_chain),
   .bus_req      (bus_req)
);

// File: tb/dbg_acc_chain_test.sv
`timescale 1ns/1ps
module dbg_acc_chain_test;

   localparam int CLK_P = 10;
   localparam logic [31:0] ID_VAL = 32'h1D0C_A5E1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ir = 4'h0;
   logic        dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
   logic        tdo;
   logic [4:0]  active_chain;
   logic        bus_req, bus_write;
   logic [6:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;

   logic [31:0] mem [0:127];
   logic [31:0] exp_hold;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dbg_acc_chain uut (
      .clk(clk), .rst_n(rst_n), .ir(ir), .dr_capture(dr_capture),
      .dr_shift(dr_shift), .dr_update(dr_update), .tdi(tdi), .tdo(tdo),
      .active_chain(active_chain), .bus_req(bus_req), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   // bench register slave: register 0 is read-only identification
   assign bus_rdata = mem[bus_addr];
   always @(posedge clk)
      if (bus_req && bus_write && bus_addr != 7'd0) mem[bus_addr] <= bus_wdata;

   function automatic logic [39:0] exp_capture(input logic [31:0] hold);
      return {8'h00, hold};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic scan_acc(input logic dir, input logic [6:0] addr, input logic [31:0] data,
                           input logic expect_req, output logic [39:0] cap);
      logic [39:0] f;
      f = {dir, addr, data};
      @(negedge clk) dr_capture = 1'b1;
      @(negedge clk) dr_capture = 1'b0;
      dr_shift = 1'b1;
      for (int i = 0; i < 40; i++) begin
         tdi = f[i];
         #1 cap[i] = tdo;
         @(negedge clk);
      end
      dr_shift = 1'b0;
      dr_update = 1'b1;
      @(negedge clk) dr_update = 1'b0;
      if (expect_req) begin
         chk("R3 req after update", 64'(bus_req), 64'd1);
         chk("R1 address field", 64'(bus_addr), 64'(addr));
         chk("R2 direction", 64'(bus_write), 64'(dir));
         if (dir) chk("R2 write data", 64'(bus_wdata), 64'(data));
         else     exp_hold = mem[addr];
      end else begin
         chk("R6 no request", 64'(bus_req), 64'd0);
      end
      @(negedge clk);
      chk("R3 single-cycle req", 64'(bus_req), 64'd0);
   endtask

   task automatic scan_sel(input logic [4:0] val, output logic [4:0] cap);
      @(negedge clk) dr_capture = 1'b1;
      @(negedge clk) dr_capture = 1'b0;
      dr_shift = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tdi = val[i];
         #1 cap[i] = tdo;
         @(negedge clk);
      end
      dr_shift = 1'b0;
      dr_update = 1'b1;
      @(negedge clk) dr_update = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [39:0] cap;
      logic [4:0]  scap;
      logic [31:0] keep7;
      void'($urandom(32'd5151));
      for (int i = 0; i < 128; i++) mem[i] = 32'(i) * 32'h0101_0101 ^ 32'h5A00_3C00;
      mem[0] = ID_VAL;
      exp_hold = 32'h0;

      repeat (2) @(negedge clk);
      chk("R8 chain in reset", 64'(active_chain), 64'd0);
      chk("R8 req in reset", 64'(bus_req), 64'd0);
      rst_n = 1'b1;
      ir = 4'hC;

      // directed: write then pipelined reads
      scan_acc(1'b1, 7'd5, 32'hA5A5_1234, 1'b1, cap);
      chk("R4 first capture zero", 64'(cap), 64'(exp_capture(32'h0)));
      scan_acc(1'b0, 7'd5, 32'h0, 1'b1, cap);
      chk("R4 capture after write", 64'(cap), 64'(exp_capture(32'h0)));
      scan_acc(1'b1, 7'd9, 32'h0BAD_F00D, 1'b1, cap);
      chk("R5 read result of addr 5", 64'(cap), 64'(exp_capture(32'hA5A5_1234)));
      scan_acc(1'b0, 7'd0, 32'h0, 1'b1, cap);
      chk("R5 write leaves hold", 64'(cap), 64'(exp_capture(32'hA5A5_1234)));
      scan_acc(1'b0, 7'd9, 32'h0, 1'b1, cap);
      chk("R5 identification read", 64'(cap), 64'(exp_capture(ID_VAL)));

      // burst of reads closed by a read of register 0
      scan_acc(1'b0, 7'd3, 32'h0, 1'b1, cap);
      chk("R5 burst step 9", 64'(cap), 64'(exp_capture(32'h0BAD_F00D)));
      scan_acc(1'b0, 7'd4, 32'h0, 1'b1, cap);
      chk("R5 burst step 3", 64'(cap), 64'(exp_capture(mem[3])));
      scan_acc(1'b0, 7'd0, 32'h0, 1'b1, cap);
      chk("R5 burst close", 64'(cap), 64'(exp_capture(mem[4])));

      // random mix
      for (int k = 0; k < 60; k++) begin
         logic        d;
         logic [6:0]  a;
         logic [31:0] v, e;
         d = 1'($urandom);
         a = 7'($urandom);
         v = $urandom;
         e = exp_hold;
         scan_acc(d, a, v, 1'b1, cap);
         chk("R1 R5 random frame", 64'(cap), 64'(exp_capture(e)));
      end

      // chain select and gating
      ir = 4'h2;
      scan_sel(5'd3, scap);
      chk("R7 capture readback 0", 64'(scap), 64'd0);
      @(negedge clk);
      chk("R7 chain updated", 64'(active_chain), 64'd3);
      keep7 = mem[7];
      ir = 4'hC;
      scan_acc(1'b1, 7'd7, 32'hFFFF_0000, 1'b0, cap);
      chk("R6 tdo quiet off chain", 64'(cap), 64'd0);
      chk("R6 register untouched", 64'(mem[7]), 64'(keep7));
      ir = 4'hF;
      scan_acc(1'b1, 7'd7, 32'h1111_2222, 1'b0, cap);
      chk("R6 other instruction", 64'(cap), 64'd0);
      ir = 4'h2;
      scan_sel(5'd0, scap);
      chk("R7 capture readback 3", 64'(scap), 64'd3);
      ir = 4'hC;
      scan_acc(1'b0, 7'd7, 32'h0, 1'b1, cap);
      scan_acc(1'b0, 7'd0, 32'h0, 1'b1, cap);
      chk("R6 value survives gated write", 64'(cap), 64'(exp_capture(keep7)));

      // reset clears chain
      ir = 4'h2;
      scan_sel(5'd21, scap);
      @(negedge clk);
      chk("R7 chain 21", 64'(active_chain), 64'd21);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 reset clears chain", 64'(active_chain), 64'd0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule